// File: doc/BRIEF.md
# Capped Multithread Issue Slot Allocator

Each clock cycle this block hands out a fixed set of issue slots (eight by default) to ready work from up to eight hardware threads. Every thread reports how many of its instructions are ready to issue; a head thread id names the thread that has the highest priority. Priority then rotates upward through the thread ids and wraps back to zero. Threads are served one after another in that order. Each takes as many slots as the smallest of three limits allows: its ready count, the per-thread cap, and the slots still free.

The per-thread cap can be changed at run time. It can be one, two or four instructions per thread per cycle, or it can be the whole width, which lets all threads compete freely for every slot. A second option, the partitioned mode, splits the slots into fixed groups, one per unit group. Each thread is tied to exactly one group. With eight threads and four groups, every group serves exactly two threads. Both mode controls are captured into a register, so a change applies to the allocation made one cycle after it was presented. The allocation result is registered. For each slot it gives a valid bit and the owning thread id, and for each thread it gives the number of slots granted.

Top module: `smt_issue_alloc`

## Requirements
- R1: While reset is asserted and after it is released, all slot valid bits, slot thread ids and per-thread grant counts are zero. The mode register resets to the full-width cap with partitioning off.
- R2: The outputs present the allocation computed from the ready counts and head id sampled at the previous rising clock edge.
- R3: cap_sel selects the per-thread cap as 0 → 1, 1 → 2, 2 → 4 and 3 → NUM_SLOTS. No thread is ever granted more than the cap in effect.
- R4: Threads are served in the order head, head+1, … modulo NUM_THREADS. Each receives the minimum of its ready count, the cap, and the slots still unassigned (within its group in partitioned mode).
- R5: In shared mode, granted slots form a contiguous run starting at slot 0. Each thread's slots are consecutive, and threads appear in service order.
- R6: A slot that is not valid carries thread id 0.
- R7: The sum of all per-thread grant counts equals the number of valid slots.
- R8: With cap 2 and eight slots, three threads with ready work fill only six slots, and four such threads fill all eight.
- R9: With link_en set, thread t may use only group t mod NUM_GROUPS. Group g owns slots g·S to g·S+S−1, where S = NUM_SLOTS/NUM_GROUPS. Slots within a group are filled from its lowest slot in service order.
- R10: A change of cap_sel or link_en affects the allocation sampled one clock edge after the edge that captured it. The allocation at the capturing edge still uses the previous mode.
- R11: The total number of valid slots never exceeds NUM_SLOTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_sel | input | 2 | Per-thread cap select (R3 encoding) |
| link_en | input | 1 | Partitioned mode enable |
| head_tid | input | TID_W | Highest-priority thread id |
| ready_cnt | input | NUM_THREADS*CNT_W | Ready count per thread; thread t at bits [t*CNT_W +: CNT_W] |
| slot_vld | output | NUM_SLOTS | Slot holds a granted instruction |
| slot_tid | output | NUM_SLOTS*TID_W | Owning thread of slot s at bits [s*TID_W +: TID_W] |
| grant_cnt | output | NUM_THREADS*SLOT_W | Slots granted to thread t at bits [t*SLOT_W +: SLOT_W] |

## Verification
The assertions check several properties on every cycle. No grant exceeds the cap or the ready count from the previous edge. Idle slots carry id zero. The grant sum matches the valid-slot count and stays within the width. Shared-mode slots form a prefix. Partitioned slots belong only to their tied threads. The exact division of slots depends on rotating priority and on the one-cycle delay of a mode change, and only the bench's behavioural reference shows these. That reference is compared every cycle over directed scenarios (cap-2 starvation, head wrap, group sharing) and a long randomized stretch.

// File: rtl/smt_issue_pkg.sv
package smt_issue_pkg;

    typedef enum logic [1:0] {
        CAP_ONE  = 2'd0,
        CAP_TWO  = 2'd1,
        CAP_FOUR = 2'd2,
        CAP_ALL  = 2'd3
    } cap_mode_e;

    // Per-thread cap for a select value, clipped to the issue width (R3)
    function automatic int cap_limit(cap_mode_e sel, int width);
        int lim;
        case (sel)
            CAP_ONE:  lim = 1;
            CAP_TWO:  lim = 2;
            CAP_FOUR: lim = 4;
            default:  lim = width;
        endcase
        if (lim > width) lim = width;
        return lim;
    endfunction

endpackage

// File: rtl/smt_mode_reg.sv
module smt_mode_reg
    import smt_issue_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cap_sel_i,
    input  logic              link_i,
    output logic [SLOT_W-1:0] cap_o,
    output logic              link_o
);

    typedef struct packed {
        cap_mode_e sel;
        logic      link;
    } mode_t;

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d      = mode_q;
        mode_d.sel  = cap_mode_e'(cap_sel_i);
        mode_d.link = link_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q.sel  <= CAP_ALL;
            mode_q.link <= 1'b0;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign cap_o  = SLOT_W'(cap_limit(mode_q.sel, NUM_SLOTS));
    assign link_o = mode_q.link;

endmodule

// File: rtl/smt_grant_calc.sv
module smt_grant_calc #(
    parameter int NUM_THREADS = 8,
    parameter int NUM_SLOTS   = 8,
    parameter int NUM_GROUPS  = 4,
    parameter int CNT_W       = 4,
    parameter int TID_W       = $clog2(NUM_THREADS),
    parameter int SLOT_W      = $clog2(NUM_SLOTS + 1)
) (
    input  logic [SLOT_W-1:0]             cap_i,
    input  logic                          link_i,
    input  logic [TID_W-1:0]              head_i,
    input  logic [NUM_THREADS*CNT_W-1:0]  ready_i,
    output logic [NUM_THREADS*SLOT_W-1:0] grant_o,
    output logic [NUM_THREADS*SLOT_W-1:0] start_o
);

    localparam int GRP_SLOTS = NUM_SLOTS / NUM_GROUPS;

    always_comb begin
        int rem_all;
        int rem_grp [NUM_GROUPS];
        int tt;
        int grp;
        int rdy;
        int avail;
        int base;
        int give;
        int cap;

        grant_o = '0;
        start_o = '0;
        cap     = int'(cap_i);
        rem_all = NUM_SLOTS;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            rem_grp[g] = GRP_SLOTS;
        end

        // Serve threads in rotating priority order (R4)
        for (int k = 0; k < NUM_THREADS; k++) begin
            tt  = (int'(head_i) + k) % NUM_THREADS;
            grp = tt % NUM_GROUPS;
            rdy = int'(ready_i[tt*CNT_W +: CNT_W]);
            if (link_i) begin
                avail = rem_grp[grp];
                base  = grp * GRP_SLOTS + (GRP_SLOTS - avail);
            end else begin
                avail = rem_all;
                base  = NUM_SLOTS - rem_all;
            end
            give = rdy;
            if (give > cap)   give = cap;
            if (give > avail) give = avail;
            grant_o[tt*SLOT_W +: SLOT_W] = SLOT_W'(give);
            start_o[tt*SLOT_W +: SLOT_W] = SLOT_W'(base);
            if (link_i) rem_grp[grp] = rem_grp[grp] - give;
            else        rem_all      = rem_all - give;
        end
    end

endmodule

// File: rtl/smt_slot_map.sv
module smt_slot_map #(
    parameter int NUM_THREADS = 8,
    parameter int NUM_SLOTS   = 8,
    parameter int TID_W       = $clog2(NUM_THREADS),
    parameter int SLOT_W      = $clog2(NUM_SLOTS + 1)
) (
    input  logic [NUM_THREADS*SLOT_W-1:0] grant_i,
    input  logic [NUM_THREADS*SLOT_W-1:0] start_i,
    output logic [NUM_SLOTS-1:0]          vld_o,
    output logic [NUM_SLOTS*TID_W-1:0]    tid_o
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic             vld_s;
        logic [TID_W-1:0] tid_s;

        always_comb begin
            int st;
            int gn;
            vld_s = 1'b0;
            tid_s = '0;
            for (int t = 0; t < NUM_THREADS; t++) begin
                st = int'(start_i[t*SLOT_W +: SLOT_W]);
                gn = int'(grant_i[t*SLOT_W +: SLOT_W]);
                if (gn > 0 && s >= st && s < st + gn) begin
                    vld_s = 1'b1;
                    tid_s = TID_W'(t);
                end
            end
        end

        assign vld_o[s]                 = vld_s;
        assign tid_o[s*TID_W +: TID_W]  = tid_s;
    end

endmodule

// File: rtl/smt_issue_alloc.sv
module smt_issue_alloc #(
    parameter int NUM_THREADS = 8,
    parameter int NUM_SLOTS   = 8,
    parameter int NUM_GROUPS  = 4,
    parameter int CNT_W       = 4,
    parameter int TID_W       = $clog2(NUM_THREADS),
    parameter int SLOT_W      = $clog2(NUM_SLOTS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    cap_sel,
    input  logic                          link_en,
    input  logic [TID_W-1:0]              head_tid,
    input  logic [NUM_THREADS*CNT_W-1:0]  ready_cnt,
    output logic [NUM_SLOTS-1:0]          slot_vld,
    output logic [NUM_SLOTS*TID_W-1:0]    slot_tid,
    output logic [NUM_THREADS*SLOT_W-1:0] grant_cnt
);

    localparam int GRP_SLOTS = NUM_SLOTS / NUM_GROUPS;

    typedef struct packed {
        logic [NUM_SLOTS-1:0]          vld;
        logic [NUM_SLOTS*TID_W-1:0]    tid;
        logic [NUM_THREADS*SLOT_W-1:0] grant;
    } alloc_t;

    alloc_t alloc_d, alloc_q;

    logic [SLOT_W-1:0]             cap_w;
    logic                          link_w;
    logic [NUM_THREADS*SLOT_W-1:0] grant_w;
    logic [NUM_THREADS*SLOT_W-1:0] start_w;
    logic [NUM_SLOTS-1:0]          vld_w;
    logic [NUM_SLOTS*TID_W-1:0]    tid_w;

    smt_mode_reg #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_sel_i (cap_sel),
        .link_i    (link_en),
        .cap_o     (cap_w),
        .link_o    (link_w)
    );

    smt_grant_calc #(
        .NUM_THREADS (NUM_THREADS),
        .NUM_SLOTS   (NUM_SLOTS),
        .NUM_GROUPS  (NUM_GROUPS),
        .CNT_W       (CNT_W),
        .TID_W       (TID_W),
        .SLOT_W      (SLOT_W)
    ) u_calc (
        .cap_i   (cap_w),
        .link_i  (link_w),
        .head_i  (head_tid),
        .ready_i (ready_cnt),
        .grant_o (grant_w),
        .start_o (start_w)
    );

    smt_slot_map #(
        .NUM_THREADS (NUM_THREADS),
        .NUM_SLOTS   (NUM_SLOTS),
        .TID_W       (TID_W),
        .SLOT_W      (SLOT_W)
    ) u_map (
        .grant_i (grant_w),
        .start_i (start_w),
        .vld_o   (vld_w),
        .tid_o   (tid_w)
    );

    always_comb begin
        alloc_d       = alloc_q;
        alloc_d.vld   = vld_w;
        alloc_d.tid   = tid_w;
        alloc_d.grant = grant_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alloc_q <= '0;
        end else begin
            alloc_q <= alloc_d;
        end
    end

    assign slot_vld  = alloc_q.vld;
    assign slot_tid  = alloc_q.tid;
    assign grant_cnt = alloc_q.grant;

    // ---------------- assertions ----------------
    int grant_sum;
    always_comb begin
        grant_sum = 0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            grant_sum = grant_sum + int'(alloc_q.grant[t*SLOT_W +: SLOT_W]);
        end
    end

    assert_grant_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant_sum == $countones(alloc_q.vld));

    assert_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
        grant_sum <= NUM_SLOTS);

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr_chk
        assert_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
            alloc_q.grant[t*SLOT_W +: SLOT_W] <= $past(cap_w));
        assert_ready_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
            int'(alloc_q.grant[t*SLOT_W +: SLOT_W]) <= int'($past(ready_cnt[t*CNT_W +: CNT_W])));
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot_chk
        assert_idle_tid_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !alloc_q.vld[s] |-> alloc_q.tid[s*TID_W +: TID_W] == '0);
        assert_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(link_w) && alloc_q.vld[s]) |->
                (int'(alloc_q.tid[s*TID_W +: TID_W]) % NUM_GROUPS) == (s / GRP_SLOTS));
        if (s > 0) begin : g_prefix
            assert_prefix_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (!$past(link_w) && alloc_q.vld[s]) |-> alloc_q.vld[s-1]);
        end
    end

endmodule

// File: tb/smt_issue_alloc_bench.sv
module smt_issue_alloc_bench;

    localparam int NT = 8;
    localparam int NS = 8;
    localparam int NG = 4;
    localparam int CW = 4;
    localparam int TW = 3;
    localparam int SW = 4;
    localparam int WATCHDOG = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cap_sel = 2'd3;
    logic              link_en = 1'b0;
    logic [TW-1:0]     head_tid = '0;
    logic [NT*CW-1:0]  ready_cnt = '0;
    logic [NS-1:0]     slot_vld;
    logic [NS*TW-1:0]  slot_tid;
    logic [NT*SW-1:0]  grant_cnt;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    int eff_sel = 3;
    int eff_link = 0;
    int exp_vld [NS];
    int exp_tid [NS];
    int exp_gr  [NT];

    always #5 clk = ~clk;

    smt_issue_alloc u_smt_issue_alloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_sel   (cap_sel),
        .link_en   (link_en),
        .head_tid  (head_tid),
        .ready_cnt (ready_cnt),
        .slot_vld  (slot_vld),
        .slot_tid  (slot_tid),
        .grant_cnt (grant_cnt)
    );

    function automatic int cap_of(int sel);
        case (sel)
            0: return 1;
            1: return 2;
            2: return 4;
            default: return NS;
        endcase
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all R): actual=hung expected=finished");
            report();
        end
    end

    // Behavioural reference: queues of slot owners per group
    task automatic model();
        int cap;
        int ngrp;
        int per;
        int q [NG][$];
        int t;
        int g;
        int take;
        cap  = cap_of(eff_sel);
        ngrp = (eff_link != 0) ? NG : 1;
        per  = NS / ngrp;
        for (int k = 0; k < NT; k++) begin
            t = (int'(head_tid) + k) % NT;
            g = (eff_link != 0) ? (t % NG) : 0;
            take = int'(ready_cnt[t*CW +: CW]);
            if (take > cap) take = cap;
            if (take > per - q[g].size()) take = per - q[g].size();
            exp_gr[t] = take;
            for (int j = 0; j < take; j++) q[g].push_back(t);
        end
        for (int s = 0; s < NS; s++) begin
            g = s / per;
            if ((s % per) < q[g].size()) begin
                exp_vld[s] = 1;
                exp_tid[s] = q[g][s % per];
            end else begin
                exp_vld[s] = 0;
                exp_tid[s] = 0;
            end
        end
    endtask

    task automatic compare(string tag);
        bit bad;
        bad = 0;
        n_chk++;
        for (int s = 0; s < NS; s++) begin
            if (int'(slot_vld[s]) != exp_vld[s] || int'(slot_tid[s*TW +: TW]) != exp_tid[s]) begin
                $display("FAIL %s slot %0d: actual vld=%0d tid=%0d expected vld=%0d tid=%0d",
                         tag, s, slot_vld[s], slot_tid[s*TW +: TW], exp_vld[s], exp_tid[s]);
                bad = 1;
            end
        end
        for (int t = 0; t < NT; t++) begin
            if (int'(grant_cnt[t*SW +: SW]) != exp_gr[t]) begin
                $display("FAIL %s grant thread %0d: actual=%0d expected=%0d",
                         tag, t, grant_cnt[t*SW +: SW], exp_gr[t]);
                bad = 1;
            end
        end
        if (bad) n_fail++;
    endtask

    // One allocation: model uses the mode captured at the previous edge (R10)
    task automatic step(string tag);
        @(posedge clk);
        model();
        eff_sel  = int'(cap_sel);
        eff_link = int'(link_en);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic set_rdy(input int v [NT]);
        for (int t = 0; t < NT; t++) ready_cnt[t*CW +: CW] = CW'(v[t]);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        for (int s = 0; s < NS; s++) begin exp_vld[s] = 0; exp_tid[s] = 0; end
        for (int t = 0; t < NT; t++) exp_gr[t] = 0;
        compare("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        // Full-width sharing
        set_rdy('{1,1,1,1,1,1,1,1});
        step("R2 R4 one each");
        set_rdy('{3,0,2,0,0,5,0,0});
        step("R5 contiguous fill");
        head_tid = 3'd5;
        step("R4 head rotation");
        head_tid = 3'd7;
        set_rdy('{15,15,15,15,15,15,15,15});
        step("R11 oversubscribed");

        // Cap two: change applies one allocation late
        head_tid = 3'd0;
        cap_sel  = 2'd1;
        set_rdy('{8,8,8,0,0,0,0,0});
        step("R10 old cap still used");
        step("R8 three threads six slots");
        set_rdy('{8,0,8,0,8,0,8,0});
        step("R8 four threads fill");

        // Cap one and cap four
        cap_sel = 2'd0;
        set_rdy('{5,5,5,5,5,5,5,5});
        step("R10 cap change delayed");
        step("R3 cap one");
        cap_sel = 2'd2;
        set_rdy('{1,6,0,9,2,0,0,7});
        step("R10 cap four pending");
        step("R3 cap four");

        // Partitioned mode
        link_en = 1'b1;
        set_rdy('{3,3,3,3,3,3,3,3});
        step("R10 link pending");
        step("R9 groups");
        head_tid = 3'd6;
        set_rdy('{1,0,4,2,1,0,4,0});
        step("R9 head in group two");
        set_rdy('{0,0,0,0,0,0,0,0});
        step("R6 empty");
        link_en = 1'b0;
        step("R7 leaving partition");

        // Randomised stretch
        for (int i = 0; i < 500; i++) begin
            cap_sel  = 2'($urandom_range(0, 3));
            link_en  = 1'($urandom_range(0, 1));
            head_tid = TW'($urandom_range(0, NT - 1));
            for (int t = 0; t < NT; t++) ready_cnt[t*CW +: CW] = CW'($urandom_range(0, 15));
            step("R7 random mix");
        end
        report();
    end

endmodule